// File: doc/BRIEF.md
# Latched Interrupt Controller with Selectable Acknowledge Polarity

This block collects a vector of interrupt lines next to a processor core and turns them into a single interrupt request. Every line owns one bit in a status register and one bit in a mask register. A line that is high sets its status bit, and the bit stays set after the line drops. This holds for edge and level sources alike. The bit stays set until software acknowledges it with a write to the status register. Pending bits are latched whatever the mask holds.

The request to the core is the OR of all status bits that the mask enables. It is ANDed with a global enable bit supplied by the core, and it is registered once before it leaves the block. Software reads and writes both registers through a simple single-cycle port, where a select bit picks the register. A build-time parameter fixes how a status bit is acknowledged. In one mode, writing a one to the bit clears it. In the other, writing a zero clears it, and software writes back the value it read with only the target bit zeroed.

Top module: `latch_irq_ctrl`

## Requirements
- R1: After reset the mask register, the status register and `core_irq` are all zero, so every line starts disabled.
- R2: A register write with `reg_wr_sel` = 0 loads `reg_wr_data` into the mask register. `reg_rd_data` shows the mask when `reg_rd_sel` = 0 and the status when `reg_rd_sel` = 1. Reads are combinational and change no state.
- R3: A line that is high at a clock edge has its status bit set after that edge. The bit stays set after the line returns low, whatever the mask bit holds. A status bit never becomes set unless its line was high at the preceding edge.
- R4: With `CLEAR_ON_ONE` = 1, a write with `reg_wr_sel` = 1 clears each status bit where `reg_wr_data` is 1 and leaves bits where it is 0 unchanged.
- R5: With `CLEAR_ON_ONE` = 0, a write with `reg_wr_sel` = 1 clears each status bit where `reg_wr_data` is 0 and leaves bits where it is 1 unchanged.
- R6: When a line is high in the same cycle as a write that would clear its status bit, the bit is set after the edge, so the event is kept.
- R7: `core_irq` is high in the cycle after an edge at which `glob_irq_en` was 1 and at least one bit of (status AND mask) was 1. This includes unmasking a bit that was already pending. Otherwise `core_irq` is low.
- R8: If `glob_irq_en` is 0 at an edge, `core_irq` is 0 after that edge, whatever is pending.
- R9: A status write leaves the mask register unchanged. A mask write clears no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_LINES | Interrupt source lines, active high |
| glob_irq_en | input | 1 | Global interrupt enable from the core status word |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 mask, 1 status |
| reg_wr_data | input | NUM_LINES | Write data |
| reg_rd_sel | input | 1 | Read source: 0 mask, 1 status |
| reg_rd_data | output | NUM_LINES | Read data, combinational |
| core_irq | output | 1 | Registered interrupt request to the core |

## Verification
The assertions assume that `irq_lines` is held low while reset is active. They also assume that the write strobe, select and data are stable around each rising edge, so that a write is seen at exactly one edge. The bench holds every input at zero through reset and changes inputs only 2 ns after a rising edge. It drives two instances, one per acknowledge mode, from the same stimulus. This lets one write pattern check write-one-to-clear and write-zero-to-clear side by side. Random traffic keeps lines sparse, so that clears often take effect and set-versus-clear collisions occur alongside plain latching.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
    // Register select encoding shared by the read and write sides
    typedef enum logic {
        SEL_MASK   = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_LINES-1:0] load_data,
    output logic [NUM_LINES-1:0] mask_q
);
    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.mask = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
endmodule

// File: rtl/irq_status_latch.sv
`timescale 1ns/1ps
module irq_status_latch #(
    parameter int NUM_LINES    = 32,
    parameter bit CLEAR_ON_ONE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 ack_wr,
    input  logic [NUM_LINES-1:0] ack_data,
    output logic [NUM_LINES-1:0] status_q
);
    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
    } latch_state_t;

    latch_state_t         st_d, st_q;
    logic [NUM_LINES-1:0] clr_hit;

    // Acknowledge polarity picked at build time
    generate
        if (CLEAR_ON_ONE) begin : g_clr_one
            assign clr_hit = ack_wr ? ack_data : '0;
        end else begin : g_clr_zero
            assign clr_hit = ack_wr ? ~ack_data : '0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            // a live line outranks an acknowledge of the same bit
            st_d.pend[i] = irq_lines[i] | (st_q.pend[i] & ~clr_hit[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.pend;
endmodule

// File: rtl/irq_req_gen.sv
`timescale 1ns/1ps
module irq_req_gen #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] status,
    input  logic [NUM_LINES-1:0] mask,
    input  logic                 glob_en,
    output logic                 req_q
);
    typedef struct packed {
        logic req;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = glob_en & (|(status & mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;
endmodule

// File: rtl/latch_irq_ctrl.sv
`timescale 1ns/1ps
module latch_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES    = 32,
    parameter bit CLEAR_ON_ONE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 glob_irq_en,
    input  logic                 reg_wr_en,
    input  logic                 reg_wr_sel,
    input  logic [NUM_LINES-1:0] reg_wr_data,
    input  logic                 reg_rd_sel,
    output logic [NUM_LINES-1:0] reg_rd_data,
    output logic                 core_irq
);
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] status_q;
    logic                 mask_wr;
    logic                 stat_wr;

    assign mask_wr = reg_wr_en && (reg_sel_e'(reg_wr_sel) == SEL_MASK);
    assign stat_wr = reg_wr_en && (reg_sel_e'(reg_wr_sel) == SEL_STATUS);

    irq_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mask_wr),
        .load_data (reg_wr_data),
        .mask_q    (mask_q)
    );

    irq_status_latch #(.NUM_LINES(NUM_LINES), .CLEAR_ON_ONE(CLEAR_ON_ONE)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .ack_wr    (stat_wr),
        .ack_data  (reg_wr_data),
        .status_q  (status_q)
    );

    irq_req_gen #(.NUM_LINES(NUM_LINES)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (status_q),
        .mask    (mask_q),
        .glob_en (glob_irq_en),
        .req_q   (core_irq)
    );

    assign reg_rd_data = (reg_sel_e'(reg_rd_sel) == SEL_STATUS) ? status_q : mask_q;
endmodule

module latch_irq_ctrl_checker #(
    parameter int NUM_LINES    = 32,
    parameter bit CLEAR_ON_ONE = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 glob_irq_en,
    input logic                 reg_wr_en,
    input logic                 reg_wr_sel,
    input logic [NUM_LINES-1:0] reg_wr_data,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] status,
    input logic                 core_irq
);
    logic [NUM_LINES-1:0] ack_pat;
    assign ack_pat = (reg_wr_en && reg_wr_sel)
                   ? (CLEAR_ON_ONE ? reg_wr_data : ~reg_wr_data) : '0;

    assert_phantom_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(irq_lines)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq_lines) & ~status) == '0));

    // R5 as well when CLEAR_ON_ONE is 0
    assert_fall_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status & $past(status) & ~$past(ack_pat)) == '0));

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |-> $past(glob_irq_en && ((status & mask) != '0)));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_irq_en |=> !core_irq);

    assert_mask_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel) |=> $stable(mask));
endmodule

bind latch_irq_ctrl latch_irq_ctrl_checker #(
    .NUM_LINES(NUM_LINES), .CLEAR_ON_ONE(CLEAR_ON_ONE)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines   (irq_lines),
    .glob_irq_en (glob_irq_en),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .mask        (mask_q),
    .status      (status_q),
    .core_irq    (core_irq)
);

// File: tb/latch_irq_ctrl_bench.sv
`timescale 1ns/1ps
module latch_irq_ctrl_bench;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_lines = '0;
    logic         glob_irq_en = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic         reg_wr_sel = 1'b0;
    logic [N-1:0] reg_wr_data = '0;
    logic         reg_rd_sel = 1'b0;
    logic [N-1:0] rd_one, rd_zero;
    logic         irq_one, irq_zero;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done = 1'b0;
    string       phase = "R1";

    always #5 clk = ~clk;

    latch_irq_ctrl #(.NUM_LINES(N), .CLEAR_ON_ONE(1'b1)) u_latch_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .glob_irq_en(glob_irq_en),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(rd_one), .core_irq(irq_one)
    );

    latch_irq_ctrl #(.NUM_LINES(N), .CLEAR_ON_ONE(1'b0)) u_legacy (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .glob_irq_en(glob_irq_en),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(rd_zero), .core_irq(irq_zero)
    );

    // Behavioural reference, updated at each rising edge
    logic [N-1:0] m_mask = '0, m_st1 = '0, m_st0 = '0;
    logic         m_irq1 = 1'b0, m_irq0 = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = '0; m_st1 = '0; m_st0 = '0; m_irq1 = 1'b0; m_irq0 = 1'b0;
        end else begin
            m_irq1 = glob_irq_en && ((m_st1 & m_mask) != 0);
            m_irq0 = glob_irq_en && ((m_st0 & m_mask) != 0);
            if (reg_wr_en && reg_wr_sel) begin
                m_st1 = m_st1 & ~reg_wr_data;
                m_st0 = m_st0 & reg_wr_data;
            end
            m_st1 = m_st1 | irq_lines;
            m_st0 = m_st0 | irq_lines;
            if (reg_wr_en && !reg_wr_sel) m_mask = reg_wr_data;
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (reg_rd_sel) begin
                check("R3 R4 R6 R9 status (clear-on-one)", rd_one, m_st1);
                check("R3 R5 R6 R9 status (clear-on-zero)", rd_zero, m_st0);
            end else begin
                check("R2 R9 mask (clear-on-one)", rd_one, m_mask);
                check("R2 R9 mask (clear-on-zero)", rd_zero, m_mask);
            end
            check("R7 R8 core_irq (clear-on-one)", {{(N-1){1'b0}}, irq_one}, {{(N-1){1'b0}}, m_irq1});
            check("R7 R8 core_irq (clear-on-zero)", {{(N-1){1'b0}}, irq_zero}, {{(N-1){1'b0}}, m_irq0});
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
        reg_wr_en = 1'b0;
        irq_lines = '0;
        reg_rd_sel = ~reg_rd_sel;
    endtask

    task automatic wr(input logic sel, input logic [N-1:0] data);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_fails++;
        $display("FAIL watchdog expired at t=%0t", $time);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        repeat (2) cyc();
        phase = "R2";
        wr(1'b0, 32'h0000_00F0); cyc(); cyc(); cyc();
        phase = "R3";
        irq_lines = 32'h0000_0020; cyc();
        irq_lines = 32'h0001_0000; cyc(); cyc(); cyc();
        phase = "R7";
        glob_irq_en = 1'b1; cyc(); cyc(); cyc();
        phase = "R8";
        glob_irq_en = 1'b0; cyc(); cyc();
        glob_irq_en = 1'b1;
        phase = "R4 R5";
        wr(1'b1, 32'h0000_0020); cyc(); cyc(); cyc();
        wr(1'b1, 32'hFFFF_FFFF); cyc(); cyc();
        wr(1'b1, 32'h0000_0000); cyc(); cyc();
        phase = "R6";
        irq_lines = 32'h0000_0080; cyc();
        irq_lines = 32'h0000_0080; wr(1'b1, 32'h0000_0080); cyc(); cyc();
        irq_lines = 32'h0000_0080; wr(1'b1, 32'h0000_0000); cyc(); cyc();
        phase = "R7 unmask";
        wr(1'b0, 32'h0000_0000); cyc();
        irq_lines = 32'h0400_0000; cyc(); cyc();
        wr(1'b0, 32'h0400_0000); cyc(); cyc(); cyc();
        phase = "R9";
        wr(1'b0, 32'hFFFF_FFFF); cyc(); cyc();
        phase = "random";
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk);
            #2;
            irq_lines   = $urandom() & $urandom() & $urandom() & $urandom();
            glob_irq_en = ($urandom_range(0, 7) != 0);
            reg_wr_en   = ($urandom_range(0, 2) == 0);
            reg_wr_sel  = ($urandom_range(0, 3) != 0);
            reg_wr_data = $urandom();
            reg_rd_sel  = $urandom_range(0, 1);
        end
        cyc(); cyc();
        finish_run();
    end
endmodule